// File: doc/BRIEF.md
# Dual Autoreload PWM Timer

This block produces four pulse-width-modulated outputs from two 12-bit up-counters. Each counter advances on a prescaler tick and, when it passes its all-ones value, reloads itself from a software-written reload value. The gap between the reload value and the all-ones value sets the PWM period. Channels 0 and 1 always compare against the first counter. Channels 2 and 3 compare against the second counter when the split mode is on, and against the first counter when it is off.

Software writes duty and polarity values into preload registers. These values reach the outputs only on an overflow of the owning counter, and only while that counter's transfer flag is set. Hardware clears the flag at each commit. This lets software update a whole group of channels at once, with no glitch part-way through a period.

Top module: `dual_reload_pwm`

## Requirements
- R1: Both counters are 12 bits wide and reset to 0. Each one advances by one on a cycle with `tick` high and holds its value on any other cycle.
- R2: When `tick` is high and a counter holds 0xFFF, that counter loads its reload value. The reload values sit at address 0 (counter A) and address 1 (counter B), use `wdata[11:0]`, reset to 0, and read back on `rdata`.
- R3: The preload duty values for channels 0 to 3 sit at addresses 2 to 5 and use `wdata[11:0]`. They read back on `rdata`. Writing one of them does not change any output until a transfer takes place.
- R4: The control register sits at address 6. Bits [3:0] hold the preload polarity of channels 0 to 3, and bit 4 is the split enable. The register resets to 0 and reads back.
- R5: The transfer flags sit at address 7: bit 0 is flag A and bit 1 is flag B. Both flags are 1 after reset. Writing a 1 to a bit sets that flag. Writing a 0 to a bit leaves that flag unchanged.
- R6: Each output `pwm_out[i]` is `(owner count < active duty i)` XOR shadow polarity i.
- R7: On an overflow of counter A while flag A is set:
  - channels 0 and 1 copy their preload duty into the active duty and their preload polarity into the shadow polarity;
  - channels 2 and 3 do the same when split is 0;
  - flag A clears.
- R8: When split is 1, channels 2 and 3 compare against counter B. They commit only on an overflow of counter B while flag B is set, and that commit clears flag B. Flag A has no effect on channels 2 and 3 in this mode.
- R9: A commit uses the preload values held before its clock edge, so a preload write in the overflow cycle waits for the next transfer. A flag write of 1 in the same cycle as the hardware clear leaves the flag set.
- R10: An overflow while the owning flag is clear leaves the active duty and the shadow polarity unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaler enable for both counters |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address, used for both write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| pwm_out | output | 4 | PWM outputs for channels 0 to 3 |

## Verification
A register write lands on the clock edge where `wr_en` is high, and `rdata` shows it from that edge onward. A counter step, a reload and a commit all take effect at the edge where the tick or overflow occurs, and `pwm_out` follows combinationally from the new register state. The bench drives inputs and advances its reference model at the falling edge, so the model always holds the state the design will reach at the next rising edge. It compares `pwm_out` and `rdata` at the following falling edge. Overflow-cycle writes are timed from the model's own counter, which means the same-edge cases in R9 hit exactly the cycle the design sees.

// File: rtl/dual_pwm_pkg.sv
package dual_pwm_pkg;
  localparam int unsigned CNT_W  = 12;
  localparam int unsigned N_CH   = 4;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_RELOAD_A = 3'd0,
    A_RELOAD_B = 3'd1,
    A_DUTY0    = 3'd2,
    A_DUTY1    = 3'd3,
    A_DUTY2    = 3'd4,
    A_DUTY3    = 3'd5,
    A_CTRL     = 3'd6,
    A_XFER     = 3'd7
  } reg_addr_e;

  localparam int unsigned SPLIT_BIT = 4;
endpackage

// File: rtl/dpwm_counter.sv
module dpwm_counter #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] reload_val,
  output logic [CW-1:0] cnt,
  output logic          ovf
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign ovf    = tick && (cnt == TOP);
  assign cnt_en = tick;

  always_comb begin
    cnt_d = cnt;
    if (cnt_en) begin
      if (ovf) cnt_d = reload_val;
      else     cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [CW-1:0] pre_duty,
  input  logic          pre_pol,
  input  logic [CW-1:0] cnt,
  output logic [CW-1:0] act_duty,
  output logic          pwm
);
  logic [CW-1:0] act_duty_d;
  logic          shd_pol, shd_pol_d;

  always_comb begin
    act_duty_d = act_duty;
    shd_pol_d  = shd_pol;
    if (commit) begin
      act_duty_d = pre_duty;
      shd_pol_d  = pre_pol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_duty <= '0;
      shd_pol  <= 1'b0;
    end else if (commit) begin
      act_duty <= act_duty_d;
      shd_pol  <= shd_pol_d;
    end
  end

  assign pwm = (cnt < act_duty) ^ shd_pol;
endmodule

// File: rtl/dpwm_regs.sv
module dpwm_regs
  import dual_pwm_pkg::*;
#(
  parameter int unsigned CW = 12,
  parameter int unsigned NC = 4,
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          clr_a,
  input  logic          clr_b,
  output logic [CW-1:0] reload_a,
  output logic [CW-1:0] reload_b,
  output logic [CW-1:0] pre_duty [NC],
  output logic [NC-1:0] pre_pol,
  output logic          split,
  output logic [1:0]    flags,
  output logic [DW-1:0] rdata
);
  logic [1:0] flag_set;
  logic [1:0] flags_d;

  assign flag_set = (wr_en && addr == A_XFER) ? wdata[1:0] : 2'b00;

  always_comb begin
    flags_d    = flags;
    flags_d[0] = (flags[0] & ~clr_a) | flag_set[0];
    flags_d[1] = (flags[1] & ~clr_b) | flag_set[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= 2'b11;
    else        flags <= flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reload_a <= '0;
    else if (wr_en && addr == A_RELOAD_A) reload_a <= wdata[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reload_b <= '0;
    else if (wr_en && addr == A_RELOAD_B) reload_b <= wdata[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_pol <= '0;
      split   <= 1'b0;
    end else if (wr_en && addr == A_CTRL) begin
      pre_pol <= wdata[NC-1:0];
      split   <= wdata[SPLIT_BIT];
    end
  end

  for (genvar g = 0; g < NC; g++) begin : g_pre
    localparam logic [AW-1:0] MY_ADDR = AW'(int'(A_DUTY0) + g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_duty[g] <= '0;
      else if (wr_en && addr == MY_ADDR) pre_duty[g] <= wdata[CW-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_RELOAD_A: rdata[CW-1:0] = reload_a;
      A_RELOAD_B: rdata[CW-1:0] = reload_b;
      A_DUTY0:    rdata[CW-1:0] = pre_duty[0];
      A_DUTY1:    rdata[CW-1:0] = pre_duty[1];
      A_DUTY2:    rdata[CW-1:0] = pre_duty[2];
      A_DUTY3:    rdata[CW-1:0] = pre_duty[3];
      A_CTRL: begin
        rdata[NC-1:0]    = pre_pol;
        rdata[SPLIT_BIT] = split;
      end
      A_XFER:     rdata[1:0] = flags;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_reload_pwm.sv
module dual_reload_pwm
  import dual_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [N_CH-1:0]   pwm_out
);
  localparam int unsigned CW = CNT_W;
  localparam int unsigned NC = N_CH;
  localparam int unsigned FIRST_SPLIT_CH = 2;

  logic [CW-1:0] reload_a, reload_b;
  logic [CW-1:0] pre_duty [NC];
  logic [CW-1:0] duty_act [NC];
  logic [NC-1:0] pre_pol;
  logic          split;
  logic [1:0]    flags;
  logic [CW-1:0] cnt_a, cnt_b;
  logic          ovf_a, ovf_b;
  logic          commit_a, commit_b;

  assign commit_a = ovf_a && flags[0];
  assign commit_b = ovf_b && flags[1] && split;

  dpwm_regs #(.CW(CW), .NC(NC), .AW(ADDR_W), .DW(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .clr_a(commit_a), .clr_b(commit_b),
    .reload_a(reload_a), .reload_b(reload_b), .pre_duty(pre_duty),
    .pre_pol(pre_pol), .split(split), .flags(flags), .rdata(rdata)
  );

  dpwm_counter #(.CW(CW)) u_cnt_a (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload_val(reload_a),
    .cnt(cnt_a), .ovf(ovf_a)
  );

  dpwm_counter #(.CW(CW)) u_cnt_b (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload_val(reload_b),
    .cnt(cnt_b), .ovf(ovf_b)
  );

  for (genvar g = 0; g < NC; g++) begin : g_ch
    logic          ch_commit;
    logic [CW-1:0] ch_cnt;
    if (g < FIRST_SPLIT_CH) begin : g_fixed
      assign ch_commit = commit_a;
      assign ch_cnt    = cnt_a;
    end else begin : g_switch
      assign ch_commit = split ? commit_b : commit_a;
      assign ch_cnt    = split ? cnt_b    : cnt_a;
    end
    dpwm_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .commit(ch_commit),
      .pre_duty(pre_duty[g]), .pre_pol(pre_pol[g]), .cnt(ch_cnt),
      .act_duty(duty_act[g]), .pwm(pwm_out[g])
    );
  end
endmodule

// File: rtl/dpwm_checker.sv
module dpwm_checker #(
  parameter int unsigned CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr_en,
  input logic [2:0]    addr,
  input logic [15:0]   wdata,
  input logic [CW-1:0] cnt_a,
  input logic [CW-1:0] reload_a,
  input logic          ovf_a,
  input logic          commit_a,
  input logic          flag_a,
  input logic [CW-1:0] duty0
);
  logic set_a;
  assign set_a = wr_en && (addr == 3'd7) && wdata[0];

  p_count_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_a != {CW{1'b1}}) |=> cnt_a == CW'($past(cnt_a) + 1'b1));

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_a));

  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_a |=> cnt_a == $past(reload_a));

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_a && !set_a) |=> !flag_a);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_a |=> flag_a);

  p_no_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_a |=> $stable(duty0));
endmodule

bind dual_reload_pwm dpwm_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .cnt_a(cnt_a), .reload_a(reload_a), .ovf_a(ovf_a),
  .commit_a(commit_a), .flag_a(flags[0]), .duty0(duty_act[0])
);

// File: tb/dual_reload_pwm_tb.sv
module dual_reload_pwm_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        wr_en;
  logic [2:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [3:0]  pwm_out;

  always #5 clk = ~clk;

  dual_reload_pwm dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  // behavioural reference state
  int m_cnt [2];
  int m_arr [2];
  int m_pre [4];
  int m_act [4];
  int m_polp [4];
  int m_pols [4];
  int m_flag [2];
  int m_split;
  int m_addr;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int m_read(input int a);
    case (a)
      0, 1:       return m_arr[a];
      2, 3, 4, 5: return m_pre[a-2];
      6:          return m_polp[0] | (m_polp[1] << 1) | (m_polp[2] << 2) |
                         (m_polp[3] << 3) | (m_split << 4);
      7:          return m_flag[0] | (m_flag[1] << 1);
      default:    return 0;
    endcase
  endfunction

  function automatic int m_pwm();
    int v = 0;
    for (int ch = 0; ch < 4; ch++) begin
      int c = (ch >= 2 && m_split != 0) ? m_cnt[1] : m_cnt[0];
      int bitv = ((c < m_act[ch]) ? 1 : 0) ^ m_pols[ch];
      v |= bitv << ch;
    end
    return v;
  endfunction

  function automatic string rd_tag(input int a);
    if (a <= 1) return "R2";
    if (a <= 5) return "R3";
    if (a == 6) return "R4";
    return "R5";
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_arr[i] = 0; m_flag[i] = 1; end
    for (int i = 0; i < 4; i++) begin m_pre[i] = 0; m_act[i] = 0; m_polp[i] = 0; m_pols[i] = 0; end
    m_split = 0;
    m_addr  = 0;
  endtask

  // compare, then drive the inputs for the next rising edge and advance the model
  task automatic step(input bit we, input int a, input int d, input bit tk);
    int ovf [2];
    int cm  [2];
    @(negedge clk);
    chk("R1 R6 R8 pwm", int'(pwm_out), m_pwm());
    chk({rd_tag(m_addr), " rdata"}, int'(rdata), m_read(m_addr));
    wr_en = we; addr = 3'(a); wdata = 16'(d); tick = tk;
    for (int i = 0; i < 2; i++) ovf[i] = (tk && m_cnt[i] == 4095) ? 1 : 0;
    cm[0] = ovf[0] & m_flag[0];
    cm[1] = ovf[1] & m_flag[1] & m_split;
    for (int ch = 0; ch < 4; ch++) begin
      int c = (ch >= 2 && m_split != 0) ? cm[1] : cm[0];
      if (c != 0) begin m_act[ch] = m_pre[ch]; m_pols[ch] = m_polp[ch]; end
    end
    for (int i = 0; i < 2; i++) begin
      if (cm[i] != 0) m_flag[i] = 0;
      if (tk) m_cnt[i] = (m_cnt[i] == 4095) ? m_arr[i] : m_cnt[i] + 1;
    end
    if (we) begin
      case (a)
        0, 1:       m_arr[a] = d & 'hFFF;
        2, 3, 4, 5: m_pre[a-2] = d & 'hFFF;
        6: begin
          for (int ch = 0; ch < 4; ch++) m_polp[ch] = (d >> ch) & 1;
          m_split = (d >> 4) & 1;
        end
        7: begin
          if (d & 1) m_flag[0] = 1;
          if (d & 2) m_flag[1] = 1;
        end
        default: ;
      endcase
    end
    m_addr = a;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(0, i % 8, 0, lfsr[2:0] != 3'b000);
    end
  endtask

  task automatic expect_rd(input string tag, input int a);
    step(0, a, 0, 0);
    #1 chk(tag, int'(rdata), m_read(a));
  endtask

  task automatic to_overflow_a();
    while (m_cnt[0] != 4095) step(0, 7, 0, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R5 reset flags", int'(dut_i.rdata), 0); // addr 0 reads reload A = 0 (R2)
    addr = 3'd7;
    #1 chk("R5 reset flags", int'(rdata), 3);
    chk("R6 reset pwm", int'(pwm_out), 0);
    addr = 3'd0;
    @(negedge clk);
    rst_n = 1'b1;

    // set up periods, duties and polarity
    step(1, 0, 'hFF0, 0);
    step(1, 1, 'hFE8, 0);
    step(1, 2, 'hFF4, 0);
    step(1, 3, 'hFF8, 0);
    step(1, 4, 'hFFA, 0);
    step(1, 5, 'hFF0, 0);
    step(1, 6, 'h02, 0);
    expect_rd("R4 ctrl readback", 6);
    // first overflow after counting up from zero (R1, R2, R7)
    while (m_cnt[0] < 'hFF0) run(1);
    run(40);
    expect_rd("R7 flag A cleared by commit", 7);

    // preload write without a transfer flag (R10)
    step(1, 2, 'hFFE, 1);
    expect_rd("R3 preload readback", 2);
    run(60);
    chk("R10 pwm kept old duty", int'(pwm_out), m_pwm());

    // zero write to flags ignored, one sets (R5)
    step(1, 7, 0, 1);
    expect_rd("R5 zero write ignored", 7);
    step(1, 7, 1, 1);
    expect_rd("R5 one write sets", 7);
    run(40);
    expect_rd("R7 commit consumed flag", 7);

    // split mode: channels 2,3 follow counter B (R8)
    step(1, 6, 'h1C, 1);
    step(1, 4, 'hFEA, 1);
    step(1, 5, 'hFF2, 1);
    step(1, 7, 2, 1);
    run(80);
    expect_rd("R8 flag B consumed", 7);
    step(1, 7, 1, 1);
    run(40);
    expect_rd("R8 flag A leaves B alone", 7);

    // same-edge write and overflow (R9)
    step(1, 7, 1, 1);
    to_overflow_a();
    step(1, 7, 1, 1);
    expect_rd("R9 set wins over clear", 7);
    to_overflow_a();
    step(1, 2, 'hFF1, 1);
    run(20);
    chk("R9 commit used prior preload", int'(pwm_out), m_pwm());
    step(1, 7, 1, 1);
    run(40);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'h0)
        step(1, 2 + int'(lfsr[6:4]) % 6, int'({4'h0, 4'hF, lfsr[15:8]}) | 'hF00, lfsr[1:0] != 0);
      else
        step(0, int'(lfsr[6:4]), 0, lfsr[2:0] != 3'b000);
    end
    expect_rd("R2 reload readback", 1);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule